// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Generator

This block turns two digital gate commands for one half-bridge leg into a low-side and a high-side gate enable. The low-side command is active low and the high-side command is active high. A single control wire may therefore drive both commands: high selects the upper switch and low selects the lower switch. Command pairs that would request both switches at once are refused, and an active-low shutdown input forces both enables off.

Whenever one enable turns off, the opposite enable is held off for a programmable number of clock cycles. This dead time is the same in both directions. A turn-on request that arrives after the dead time has already run out is followed with no extra delay. A request that arrives inside the dead time waits only for the part of the dead time that is left. Turning the same switch back on, for example after a shutdown pulse used for chopping, is never delayed. All three inputs pass through a two-stage synchroniser, so a command change reaches the enables three clock edges after it is applied.

Top module: `hb_deadtime_gen`

## Requirements
- R1: While the synchronous reset is high, both enables are low from the next clock edge onward.
- R2: When the shutdown input is low, both enables are low three edges later, whatever the other commands are.
- R3: With shutdown high, the pair lo_cmd_n_i=0 and hi_cmd_i=0 turns on only the low-side enable. The pair lo_cmd_n_i=1 and hi_cmd_i=1 turns on only the high-side enable.
- R4: The pair lo_cmd_n_i=0 and hi_cmd_i=1 is an illegal overlap and leaves both enables off. The pair lo_cmd_n_i=1 and hi_cmd_i=0 also leaves both enables off, so the bridge floats.
- R5: The two enables are never high in the same cycle.
- R6: Let D be the dead_cycles_i value sampled at the edge where an enable turns off, or 1 if that value is 0. The opposite enable then turns on no earlier than D edges later. The same D applies for low-to-high and for high-to-low.
- R7: If the opposite request reaches the decision stage before D edges have passed, the opposite enable turns on exactly D edges after the turn-off.
- R8: If the opposite request arrives after the dead time has run out, or if no enable has been on since reset, the enable turns on three edges after the command is applied.
- R9: Turning the same enable back on after it was turned off, by shutdown or by a float command, is not subject to the dead time.
- R10: When one signal drives both commands, the enables are complementary and separated by the dead time in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shdn_n_i | input | 1 | Shutdown, active low; low forces both enables off |
| lo_cmd_n_i | input | 1 | Low-side command, active low |
| hi_cmd_i | input | 1 | High-side command, active high |
| dead_cycles_i | input | 16 | Dead time in clock cycles; 0 behaves as 1 |
| lo_gate_o | output | 1 | Low-side gate enable |
| hi_gate_o | output | 1 | High-side gate enable |

## Verification
The bench measures the dead time to the exact edge in both directions, and at the minimum setting of zero. A counter that is off by one would turn the opposite switch on one cycle early or one cycle late, and these tests would catch it. It places an opposite request inside the dead time and another one well after it. A design that restarted the count on the request would show up on the first, and a design that always waited a full dead time would show up on the second. It also restores the same switch right after a short shutdown: a design that applied the dead time there would stay dark for the whole count. It drives the illegal overlap pair and the float pair to confirm that neither one ever produces an enable.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_LO  = 2'd1,
        LEG_HI  = 2'd2
    } leg_t;

    typedef struct packed {
        logic shdn_n;
        logic lo_n;
        logic hi;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    // Safe value held in the synchroniser during reset: shut down, nothing requested.
    localparam cmd_t CMD_SAFE = '{shdn_n: 1'b0, lo_n: 1'b1, hi: 1'b0};

    function automatic leg_t leg_decode(input cmd_t c);
        if (!c.shdn_n)
            return LEG_OFF;
        if (!c.lo_n && !c.hi)
            return LEG_LO;
        if (c.lo_n && c.hi)
            return LEG_HI;
        return LEG_OFF;
    endfunction

endpackage

// File: rtl/hb_cmd_sync.sv
module hb_cmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= RST_VAL;
                else if (s == 0)
                    stg[s] <= d_i;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            expired_o
);
    logic [DT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_i)
            cnt <= (dead_i == '0) ? '0 : dead_i - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/hb_leg_ctrl.sv
module hb_leg_ctrl
    import hb_dt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  leg_t req_i,
    input  logic expired_i,
    output logic load_o,
    output leg_t state_o
);
    leg_t st, st_nxt;
    leg_t last_on;

    always_comb begin
        st_nxt = st;
        load_o = 1'b0;
        unique case (st)
            LEG_LO, LEG_HI: begin
                if (req_i != st) begin
                    st_nxt = LEG_OFF;
                    load_o = 1'b1;
                end
            end
            default: begin
                if (req_i != LEG_OFF &&
                    (req_i == last_on || last_on == LEG_OFF || expired_i))
                    st_nxt = req_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LEG_OFF;
            last_on <= LEG_OFF;
        end else begin
            st <= st_nxt;
            if (st != LEG_OFF && st_nxt == LEG_OFF)
                last_on <= st;
        end
    end

    assign state_o = st;
endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen
    import hb_dt_pkg::*;
#(
    parameter int DT_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shdn_n_i,
    input  logic            lo_cmd_n_i,
    input  logic            hi_cmd_i,
    input  logic [DT_W-1:0] dead_cycles_i,
    output logic            lo_gate_o,
    output logic            hi_gate_o
);
    cmd_t             raw_cmd, sync_cmd;
    logic [CMD_W-1:0] sync_bits;
    leg_t             req, leg_state;
    logic             tmr_load, tmr_expired;

    assign raw_cmd = '{shdn_n: shdn_n_i, lo_n: lo_cmd_n_i, hi: hi_cmd_i};

    hb_cmd_sync #(
        .W       (CMD_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CMD_SAFE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_cmd),
        .q_o (sync_bits)
    );

    assign sync_cmd = cmd_t'(sync_bits);
    assign req      = leg_decode(sync_cmd);

    hb_dead_timer #(.DT_W(DT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .dead_i    (dead_cycles_i),
        .expired_o (tmr_expired)
    );

    hb_leg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .expired_i (tmr_expired),
        .load_o    (tmr_load),
        .state_o   (leg_state)
    );

    assign lo_gate_o = (leg_state == LEG_LO);
    assign hi_gate_o = (leg_state == LEG_HI);
endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk
    import hb_dt_pkg::*;
#(
    parameter int DT_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            shdn_n_i,
    input logic            lo_cmd_n_i,
    input logic            hi_cmd_i,
    input logic [DT_W-1:0] dead_cycles_i,
    input logic            lo_gate_o,
    input logic            hi_gate_o
);
    logic            prev_lo, prev_hi;
    logic [DT_W-1:0] prev_dt, dt_cap;
    logic [DT_W:0]   gap;
    leg_t            side;
    logic [1:0]      hist;
    logic [DT_W:0]   dt_eff;

    assign dt_eff = (dt_cap == '0) ? {{DT_W{1'b0}}, 1'b1} : {1'b0, dt_cap};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lo <= 1'b0;
            prev_hi <= 1'b0;
            prev_dt <= '0;
            dt_cap  <= '0;
            gap     <= '0;
            side    <= LEG_OFF;
            hist    <= '0;
        end else begin
            prev_lo <= lo_gate_o;
            prev_hi <= hi_gate_o;
            prev_dt <= dead_cycles_i;
            if (hist != 2'd3)
                hist <= hist + 1'b1;
            if (prev_lo && !lo_gate_o) begin
                gap    <= {{DT_W{1'b0}}, 1'b1};
                side   <= LEG_LO;
                dt_cap <= prev_dt;
            end else if (prev_hi && !hi_gate_o) begin
                gap    <= {{DT_W{1'b0}}, 1'b1};
                side   <= LEG_HI;
                dt_cap <= prev_dt;
            end else if (!lo_gate_o && !hi_gate_o && gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!lo_gate_o && !hi_gate_o));

    // R2
    shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hist == 2'd3 && !$past(shdn_n_i, 3)) |-> (!lo_gate_o && !hi_gate_o));

    // R4
    overlap_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (hist == 2'd3 && $past(!lo_cmd_n_i && hi_cmd_i, 3)) |-> (!lo_gate_o && !hi_gate_o));

    // R4
    float_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (hist == 2'd3 && $past(lo_cmd_n_i && !hi_cmd_i, 3)) |-> (!lo_gate_o && !hi_gate_o));

    // R5
    no_cross_conduct_chk: assert property (@(posedge clk) disable iff (rst)
        !(lo_gate_o && hi_gate_o));

    // R6
    hi_after_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_gate_o && !prev_hi && side == LEG_LO) |-> (gap >= dt_eff));

    // R6
    lo_after_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_gate_o && !prev_lo && side == LEG_HI) |-> (gap >= dt_eff));
endmodule

bind hb_deadtime_gen hb_deadtime_chk #(.DT_W(DT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .shdn_n_i      (shdn_n_i),
    .lo_cmd_n_i    (lo_cmd_n_i),
    .hi_cmd_i      (hi_cmd_i),
    .dead_cycles_i (dead_cycles_i),
    .lo_gate_o     (lo_gate_o),
    .hi_gate_o     (hi_gate_o)
);

// File: tb/hb_deadtime_gen_tb.sv
module hb_deadtime_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shdn_n = 1'b1;
    logic        lo_n = 1'b1;
    logic        hi = 1'b1;
    logic [15:0] dead = 16'd0;
    logic        lo_g, hi_g;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit overlap_seen = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .shdn_n_i      (shdn_n),
        .lo_cmd_n_i    (lo_n),
        .hi_cmd_i      (hi),
        .dead_cycles_i (dead),
        .lo_gate_o     (lo_g),
        .hi_gate_o     (hi_g)
    );

    // vector: {shdn_n, lo_n, hi, expected lo, expected hi}
    localparam int NVEC = 10;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b10010, 5'b11101, 5'b10100, 5'b11000, 5'b10010,
        5'b00000, 5'b01100, 5'b11101, 5'b00100, 5'b10010
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic s, input logic l, input logic h);
        shdn_n = s;
        lo_n   = l;
        hi     = h;
    endtask

    task automatic check(input string req, input logic exp_lo, input logic exp_hi);
        n_chk++;
        if (lo_g !== exp_lo || hi_g !== exp_hi) begin
            n_fail++;
            $display("FAIL %s: lo=%b hi=%b expected lo=%b hi=%b at %0t",
                     req, lo_g, hi_g, exp_lo, exp_hi, $time);
        end
    endtask

    always @(negedge clk)
        if (!rst && lo_g === 1'b1 && hi_g === 1'b1)
            overlap_seen = 1'b1;

    initial begin
        // R1: reset holds both low while the commands ask for the high side
        step(5);
        check("R1 during reset", 1'b0, 1'b0);
        rst = 1'b0;
        step(3);
        check("R8 first turn-on after reset", 1'b0, 1'b1);

        // Table walk with dead time 2: R2, R3, R4
        dead = 16'd2;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][4], VEC[i][3], VEC[i][2]);
            step(8);
            if (!VEC[i][4])
                check("R2 vector", VEC[i][1], VEC[i][0]);
            else if (VEC[i][3] == VEC[i][2])
                check("R3 vector", VEC[i][1], VEC[i][0]);
            else
                check("R4 vector", VEC[i][1], VEC[i][0]);
        end

        // R10 / R6: one wire on both commands, dead time 5, low to high
        dead = 16'd5;
        drive(1'b1, 1'b0, 1'b0);
        step(10);
        check("R10 low side on", 1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b1);
        step(2);
        check("R6 before turn-off", 1'b1, 1'b0);
        step(1);
        check("R6 low turned off", 1'b0, 1'b0);
        step(4);
        check("R6 still in dead time", 1'b0, 1'b0);
        step(1);
        check("R10 high on after dead time", 1'b0, 1'b1);
        // high to low, same dead time
        drive(1'b1, 1'b0, 1'b0);
        step(3);
        check("R6 high turned off", 1'b0, 1'b0);
        step(4);
        check("R6 symmetric dead time", 1'b0, 1'b0);
        step(1);
        check("R10 low on after dead time", 1'b1, 1'b0);

        // R6: zero setting behaves as one cycle
        dead = 16'd0;
        step(10);
        drive(1'b1, 1'b1, 1'b1);
        step(3);
        check("R6 zero setting off cycle", 1'b0, 1'b0);
        step(1);
        check("R6 zero setting one cycle", 1'b0, 1'b1);

        // R7: request inside the dead time
        dead = 16'd10;
        drive(1'b1, 1'b0, 1'b0);
        step(30);
        drive(1'b1, 1'b1, 1'b0);
        step(2);
        drive(1'b1, 1'b1, 1'b1);
        step(3);
        check("R7 floating during wait", 1'b0, 1'b0);
        step(7);
        check("R7 waits rest of dead time", 1'b0, 1'b0);
        step(1);
        check("R7 on at dead time end", 1'b0, 1'b1);

        // R8: request long after the dead time
        drive(1'b1, 1'b0, 1'b0);
        step(30);
        drive(1'b1, 1'b1, 1'b0);
        step(30);
        drive(1'b1, 1'b1, 1'b1);
        step(2);
        check("R8 not yet", 1'b0, 1'b0);
        step(1);
        check("R8 no added delay", 1'b0, 1'b1);

        // R9: same side back on after a short shutdown pulse
        dead = 16'd20;
        drive(1'b1, 1'b0, 1'b0);
        step(40);
        drive(1'b0, 1'b0, 1'b0);
        step(3);
        check("R9 shutdown took effect", 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        step(3);
        check("R9 same side not delayed", 1'b1, 1'b0);

        // R1: reset in the middle of operation
        rst = 1'b1;
        step(1);
        check("R1 reset mid-run", 1'b0, 1'b0);
        rst = 1'b0;
        step(2);

        // R5: never both on
        n_chk++;
        if (overlap_seen) begin
            n_fail++;
            $display("FAIL R5: overlap=1 expected overlap=0");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule